// File: doc/BRIEF.md
# Serial-Style Character Display Port

This block gives an 8-bit processor a character display that software drives as if it were a serial transmitter. The processor sees two registers, selected by one register-select line. With select low, a write goes to a control register and a read returns a status byte. With select high, a write hands one character to the display. There is no keyboard, so the receive side is stubbed: it never reports data, and a read of the data register returns zero. The modem lines are also tied to fixed values.

On the display side a one-entry holding register offers the character to a renderer through a valid/ready handshake. The transmit-empty status flag shows whether the renderer has taken the last character. Software polls that flag before each write. It can also enable an interrupt that is raised while the holding register is empty. A control write with the low two bits set to 11 returns the port to its idle state.

Top module: `acia_disp_port`

## Requirements
- R1: After reset, `chr_valid` is 0 and `irq_n` is 1. A status read (`reg_sel`=0) returns 0x02.
- R2: Status bit 0 (receive full) always reads 0. Bit 2 (carrier detect) and bit 3 (clear to send) always read 0, meaning carrier present and clear to send. Bits 6:4 always read 0.
- R3: A data write (`reg_sel`=1) to an empty holding register sets `chr_valid` from the next clock. From then on `chr_data` equals the written byte and status bit 1 (transmit empty) reads 0.
- R4: On a clock where `chr_valid` and `chr_ready` are both 1, the character is taken. `chr_valid` then falls and status bit 1 reads 1 from the next clock.
- R5: A data write while `chr_valid` is 1 is dropped. `chr_data` keeps the earlier character, and the dropped byte is never offered to the renderer.
- R6: Each write-strobe assertion acts exactly once, however many clocks `wr_n` stays low. A data write held low across an accept therefore yields a single character.
- R7: Control bits 6:5 set the transmitter mode. The interrupt is pending only when the mode is 01 and transmit empty is 1. A pending interrupt reads as status bit 7 = 1 and drives `irq_n` low. Modes 00, 10 and 11 never raise it, and control bit 7 has no effect on it.
- R8: A control write with bits 1:0 = 11 is a master reset, whatever the other bits hold. It empties the holding register and sets the mode to 00, so `irq_n` goes high and status reads 0x02.
- R9: A read with `reg_sel`=1 returns 0x00.
- R10: While `rd_n` is high, `dout` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| reg_sel | input | 1 | 0 = control/status, 1 = data |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Read data to the processor |
| chr_data | output | 8 | Character offered to the renderer |
| chr_valid | output | 1 | Holding register is full |
| chr_ready | input | 1 | Renderer accepts the character |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The checker assumes that every input changes only between clock edges. It also assumes that `din` and `reg_sel` are already valid on the first clock that sees `wr_n` low, because that is the only clock on which a write is taken. The bench drives all inputs on the falling edge and sets the address and data together with the strobe, so both assumptions hold. The renderer's ready line is raised and dropped freely, including while no character is held. This exercises both the accept path and a ready that arrives while the register is empty.

// File: rtl/disp_port_pkg.sv
package disp_port_pkg;

    localparam int BYTE_W = 8;
    localparam int TXC_W  = 2;
    localparam logic [1:0] MRESET_CODE = 2'b11;

    typedef enum logic [TXC_W-1:0] {
        TXC_QUIET   = 2'b00,
        TXC_IRQ_ON  = 2'b01,
        TXC_RTS_OFF = 2'b10,
        TXC_BREAK   = 2'b11
    } txc_e;

    typedef struct packed {
        logic       irq;
        logic [2:0] spare;
        logic       cts;
        logic       dcd;
        logic       tx_empty;
        logic       rx_full;
    } stat_t;

    function automatic stat_t make_status(logic empty, txc_e mode);
        stat_t s;
        s.irq      = empty && (mode == TXC_IRQ_ON);
        s.spare    = '0;
        s.cts      = 1'b0;
        s.dcd      = 1'b0;
        s.tx_empty = empty;
        s.rx_full  = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/strobe_once.sv
module strobe_once (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic pulse
);
    logic was_active;

    always_ff @(posedge clk) begin
        if (rst) was_active <= 1'b0;
        else     was_active <= ~strobe_n;
    end

    assign pulse = ~strobe_n & ~was_active;
endmodule

// File: rtl/txc_reg.sv
module txc_reg
    import disp_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             mreset,
    input  logic [TXC_W-1:0] mode_in,
    output txc_e             mode
);
    always_ff @(posedge clk) begin
        if (rst || mreset) mode <= TXC_QUIET;
        else if (we)       mode <= txc_e'(mode_in);
    end
endmodule

// File: rtl/char_hold.sv
module char_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            valid <= 1'b0;
            data  <= '0;
        end else if (valid) begin
            if (ready) valid <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
            data  <= load_val;
        end
    end
endmodule

// File: rtl/acia_disp_port.sv
module acia_disp_port
    import disp_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              reg_sel,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout,
    output logic [BYTE_W-1:0] chr_data,
    output logic              chr_valid,
    input  logic              chr_ready,
    output logic              irq_n
);
    localparam int TXC_LSB = 5;

    logic  wr_pulse, ctrl_we, data_we, mreset;
    txc_e  mode;
    stat_t status;

    strobe_once u_wr (
        .clk      (clk),
        .rst      (rst),
        .strobe_n (wr_n),
        .pulse    (wr_pulse)
    );

    assign ctrl_we = wr_pulse & ~reg_sel;
    assign data_we = wr_pulse &  reg_sel;
    assign mreset  = ctrl_we & (din[1:0] == MRESET_CODE);

    txc_reg u_txc (
        .clk     (clk),
        .rst     (rst),
        .we      (ctrl_we),
        .mreset  (mreset),
        .mode_in (din[TXC_LSB +: TXC_W]),
        .mode    (mode)
    );

    char_hold #(.W(BYTE_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .clear    (mreset),
        .load     (data_we),
        .load_val (din),
        .ready    (chr_ready),
        .valid    (chr_valid),
        .data     (chr_data)
    );

    assign status = make_status(~chr_valid, mode);
    assign irq_n  = ~status.irq;

    always_comb begin
        if (rd_n || reg_sel) dout = '0;
        else                 dout = status;
    end
endmodule

// File: rtl/acia_disp_port_chk.sv
module acia_disp_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_n,
    input logic       rd_n,
    input logic       reg_sel,
    input logic [7:0] din,
    input logic [7:0] dout,
    input logic [7:0] chr_data,
    input logic       chr_valid,
    input logic       chr_ready,
    input logic       irq_n
);
    a_r2_fixed_bits: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && !reg_sel) |-> (dout[6:2] == 5'd0 && dout[0] == 1'b0));

    a_r3_load_char: assert property (@(posedge clk) disable iff (rst)
        ($fell(wr_n) && reg_sel && !chr_valid) |=> (chr_valid && chr_data == $past(din)));

    a_r4_accept_drops: assert property (@(posedge clk) disable iff (rst)
        (chr_valid && chr_ready) |=> !chr_valid);

    a_r5_full_holds: assert property (@(posedge clk) disable iff (rst)
        (chr_valid && !chr_ready && !(!wr_n && !reg_sel)) |=> (chr_valid && $stable(chr_data)));

    a_r7_irq_bit_matches_pin: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && !reg_sel) |-> (dout[7] == !irq_n));

    a_r7_irq_needs_empty: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> !chr_valid);

    a_r9_data_read_zero: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && reg_sel) |-> (dout == 8'h00));

    a_r10_idle_bus: assert property (@(posedge clk) disable iff (rst)
        rd_n |-> (dout == 8'h00));
endmodule

bind acia_disp_port acia_disp_port_chk u_chk (.*);

// File: tb/acia_disp_port_test.sv
module acia_disp_port_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_n = 1'b1, rd_n = 1'b1, reg_sel = 1'b0, chr_ready = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout, chr_data;
    logic       chr_valid, irq_n;

    int n_chk = 0, n_bad = 0, n_acc = 0;
    logic [7:0] last_acc = 8'h00;
    bit done = 1'b0;

    always #2 clk = ~clk;

    acia_disp_port uut (
        .clk(clk), .rst(rst), .wr_n(wr_n), .rd_n(rd_n), .reg_sel(reg_sel),
        .din(din), .dout(dout), .chr_data(chr_data), .chr_valid(chr_valid),
        .chr_ready(chr_ready), .irq_n(irq_n)
    );

    always @(negedge clk) begin
        #1;
        if (!rst && chr_valid && chr_ready) begin
            n_acc++;
            last_acc = chr_data;
        end
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic sel, logic [7:0] d, int hold = 1);
        @(negedge clk);
        reg_sel = sel; din = d; wr_n = 1'b0;
        repeat (hold) @(negedge clk);
        wr_n = 1'b1;
        #1;
    endtask

    task automatic rd(logic sel, output logic [7:0] v);
        @(negedge clk);
        reg_sel = sel; rd_n = 1'b0;
        #1 v = dout;
        @(negedge clk);
        rd_n = 1'b1;
        #1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 valid", {7'd0, chr_valid}, 8'h00);
        check("R1 irq_n", {7'd0, irq_n}, 8'h01);
        check("R10 idle dout", dout, 8'h00);
        rd(1'b0, v);
        check("R1 R2 status", v, 8'h02);
    endtask

    task automatic t_init();
        logic [7:0] v;
        wr(1'b0, 8'h03);
        wr(1'b0, 8'h20);
        rd(1'b0, v);
        check("R7 status irq", v, 8'h82);
        check("R7 irq_n low", {7'd0, irq_n}, 8'h00);
    endtask

    task automatic t_load_and_full();
        logic [7:0] v;
        chr_ready = 1'b0;
        wr(1'b1, 8'h41);
        check("R3 valid", {7'd0, chr_valid}, 8'h01);
        check("R3 data", chr_data, 8'h41);
        rd(1'b0, v);
        check("R3 status busy", v, 8'h00);
        check("R7 irq_n high when full", {7'd0, irq_n}, 8'h01);
        wr(1'b1, 8'h42);
        check("R5 data kept", chr_data, 8'h41);
        check("R5 still valid", {7'd0, chr_valid}, 8'h01);
        rd(1'b1, v);
        check("R9 data read", v, 8'h00);
    endtask

    task automatic t_accept();
        logic [7:0] v;
        int a0 = n_acc;
        @(negedge clk);
        chr_ready = 1'b1;
        @(negedge clk);
        #1;
        chr_ready = 1'b0;
        check("R4 valid dropped", {7'd0, chr_valid}, 8'h00);
        check("R4 one accept", 8'(n_acc - a0), 8'h01);
        check("R5 accepted first char", last_acc, 8'h41);
        rd(1'b0, v);
        check("R4 status empty", v, 8'h82);
    endtask

    task automatic t_held_strobe();
        int a0 = n_acc;
        @(negedge clk);
        chr_ready = 1'b1;
        wr(1'b1, 8'h55, 5);
        repeat (3) @(negedge clk);
        #1;
        chr_ready = 1'b0;
        check("R6 single accept", 8'(n_acc - a0), 8'h01);
        check("R6 char", last_acc, 8'h55);
        check("R6 empty after", {7'd0, chr_valid}, 8'h00);
    endtask

    task automatic t_modes();
        logic [7:0] v;
        wr(1'b0, 8'h40);
        rd(1'b0, v);
        check("R7 mode 10", v, 8'h02);
        wr(1'b0, 8'h60);
        rd(1'b0, v);
        check("R7 mode 11", v, 8'h02);
        check("R7 irq_n mode 11", {7'd0, irq_n}, 8'h01);
        wr(1'b0, 8'h80);
        rd(1'b0, v);
        check("R7 bit7 alone", v, 8'h02);
        wr(1'b0, 8'hA0);
        rd(1'b0, v);
        check("R7 mode 01 bit7", v, 8'h82);
    endtask

    task automatic t_mreset();
        logic [7:0] v;
        chr_ready = 1'b0;
        wr(1'b1, 8'h33);
        check("R8 pre valid", {7'd0, chr_valid}, 8'h01);
        wr(1'b0, 8'h23);
        check("R8 hold cleared", {7'd0, chr_valid}, 8'h00);
        check("R8 irq_n high", {7'd0, irq_n}, 8'h01);
        rd(1'b0, v);
        check("R8 status", v, 8'h02);
        wr(1'b1, 8'h7E);
        check("R3 load after reset", chr_data, 8'h7E);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        t_reset();
        t_init();
        t_load_and_full();
        t_accept();
        t_held_strobe();
        t_modes();
        t_mreset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule